// File: doc/BRIEF.md
# Video RAM Block-Copy DMA Engine

This engine copies data from anywhere in a 16-bit CPU address space into the video RAM window at 0x8000–0x9FFF, sixteen bytes at a time. Software loads a source address and a destination address into four byte-wide registers. It then writes a fifth control register, which holds a block count and a mode bit. In general mode the whole transfer runs at once, and the CPU is held off for its full duration. In blanking mode the engine waits, then moves one 16-byte block for each horizontal-blank pulse it receives.

The engine masters a simple byte bus: an address, a read-data return sampled in the same cycle, write data and a write strobe. Each byte costs one read cycle followed by one write cycle, and `cpu_stall` is high in both. The source is aligned down to 16 bytes. The destination is aligned and folded into the video window. A start whose aligned source lies inside video RAM is refused. When a transfer ends, the final addresses are written back into the address registers, and the control register is marked as complete.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset all five registers read 0x00 and `bus_addr`, `bus_we`, `bus_wdata` and `cpu_stall` are zero. Readback selector 0 gives source high, 1 source low, 2 destination high, 3 destination low and 4 control. Selectors 5–7 read 0xFF.
- R2: A start takes the source from selectors 0 (high byte) and 1 (low byte) with bits 3:0 cleared. The source steps by one per byte and wraps within 16 bits.
- R3: If the aligned source lies in 0x8000–0x9FFF, a control write is ignored entirely: the control register keeps its value and no transfer begins. An aligned source of 0xA000 is accepted.
- R4: The destination is ({sel2, sel3} AND 0x1FF0) OR 0x8000. No write ever leaves 0x8000–0x9FFF.
- R5: Control bit 7 selects the mode: 1 is blanking mode, 0 is general mode. A general transfer begins its first read in the cycle after the control write. A blanking transfer waits without stalling.
- R6: A general transfer moves (control[6:0]+1)×16 bytes, with `cpu_stall` high continuously for exactly two cycles per byte.
- R7: Each byte is a read cycle (`bus_addr` = source, `bus_we` = 0) followed directly by a write cycle (`bus_addr` = destination, `bus_we` = 1, `bus_wdata` = the `bus_rdata` seen in the read cycle).
- R8: The destination steps by one per byte inside the 13-bit window, so 0x9FFF is followed by 0x8000.
- R9: At the end of a transfer, the source and destination following the last byte are written into selectors 0–3. In blanking mode this happens only after the last block.
- R10: When a general transfer ends, control bit 7 is set and bits 6:0 are kept.
- R11: In blanking mode, each `hblank_pulse` that arrives while the engine waits moves exactly one block (32 stalled cycles). A pulse that arrives while a block is moving, or while the engine is idle, has no effect.
- R12: In blanking mode the control register drops by one after every block. The transfer ends after control[6:0]+1 blocks and leaves the control register at 0x7F.
- R13: A control write while a transfer is pending or running is ignored. Writes to selectors 0–3 during a transfer are stored but do not change the running copy, and the writeback at completion replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selected for the write |
| cfg_wdata | input | 8 | Register write value |
| cfg_rsel | input | 3 | Register selected for readback |
| cfg_rdata | output | 8 | Readback value of the selected register |
| hblank_pulse | input | 1 | One-cycle horizontal-blank event |
| bus_addr | output | 16 | Bus address for the current read or write |
| bus_rdata | input | 8 | Read data returned for `bus_addr` in the same cycle |
| bus_wdata | output | 8 | Byte being written |
| bus_we | output | 1 | Write strobe (low during read cycles) |
| cpu_stall | output | 1 | Holds the CPU off the bus while bytes move |

## Verification
The per-cycle checks cover the bus protocol: a read is always followed by exactly one write, every write lands in the video window while the CPU is stalled and carries the byte read just before it, and back-to-back reads step the source by one. Other behaviour depends on the history of register writes and blanking pulses, and only the bench's scenarios can show it: transfer length, refusal of starts aimed at video RAM or issued while busy, the control-register decrement and completion flag, wrapping of both addresses, and the final writeback. The bench's reference model predicts every bus output and register value on every clock across those scenarios.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

  localparam int ADDR_W = 16;
  localparam int REG_W  = 8;
  localparam int LEN_W  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } hdma_state_e;

  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTL    = 3'd4
  } hdma_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic              blank_mode;
    logic [LEN_W-1:0]  blocks;
  } hdma_cmd_t;

endpackage

// File: rtl/hdma_regs.sv
// Register file: holds the addresses and control byte, validates starts,
// and takes completion updates from the sequencer.
module hdma_regs
  import hdma_pkg::*;
#(
  parameter int              BLOCK_LOG2 = 4,
  parameter int              WIN_W      = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [2:0]        cfg_rsel,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              busy,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_src,
  input  logic [ADDR_W-1:0] wb_dst,
  input  logic              ctl_done,
  input  logic              ctl_dec,
  output logic              start,
  output hdma_cmd_t         cmd
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << BLOCK_LOG2) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] WIN_MASK   = (ADDR_W'(1) << WIN_W) - ADDR_W'(1);

  logic [REG_W-1:0]  src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, ctl_q;
  logic [ADDR_W-1:0] src_aligned, dst_aligned;
  logic              src_in_window;
  logic              ctl_write;

  // Start-time address shaping
  always_comb begin
    src_aligned   = {src_hi_q, src_lo_q} & ALIGN_MASK;
    dst_aligned   = ({dst_hi_q, dst_lo_q} & WIN_MASK & ALIGN_MASK) | WIN_BASE;
    src_in_window = (src_aligned & ~WIN_MASK) == WIN_BASE;
    ctl_write     = cfg_we && (cfg_sel == SEL_CTL);
    start         = ctl_write && !busy && !src_in_window;
    cmd.src        = src_aligned;
    cmd.dst        = dst_aligned;
    cmd.blank_mode = cfg_wdata[REG_W-1];
    cmd.blocks     = cfg_wdata[LEN_W-1:0];
  end

  // Address registers: software writes, engine writeback wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
    end else if (wb_en) begin
      src_hi_q <= wb_src[ADDR_W-1:REG_W];
      src_lo_q <= wb_src[REG_W-1:0];
      dst_hi_q <= wb_dst[ADDR_W-1:REG_W];
      dst_lo_q <= wb_dst[REG_W-1:0];
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_SRC_HI: src_hi_q <= cfg_wdata;
        SEL_SRC_LO: src_lo_q <= cfg_wdata;
        SEL_DST_HI: dst_hi_q <= cfg_wdata;
        SEL_DST_LO: dst_lo_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // Control byte: accepted only on a valid start, then updated by the engine
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (start) begin
      ctl_q <= cfg_wdata;
    end else if (ctl_done) begin
      ctl_q <= ctl_q | {1'b1, {(REG_W-1){1'b0}}};
    end else if (ctl_dec) begin
      ctl_q <= ctl_q - REG_W'(1);
    end
  end

  always_comb begin
    case (cfg_rsel)
      SEL_SRC_HI: cfg_rdata = src_hi_q;
      SEL_SRC_LO: cfg_rdata = src_lo_q;
      SEL_DST_HI: cfg_rdata = dst_hi_q;
      SEL_DST_LO: cfg_rdata = dst_lo_q;
      SEL_CTL:    cfg_rdata = ctl_q;
      default:    cfg_rdata = '1;
    endcase
  end

endmodule

// File: rtl/hdma_seq.sv
// Transfer sequencer: walks bytes and blocks, and reports block ends
// and completion to the register file.
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int BLOCK_LOG2 = 4,
  parameter int WIN_W      = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  hdma_cmd_t         cmd,
  input  logic              hblank_pulse,
  output hdma_state_e       state_q,
  output hdma_state_e       state_d,
  output logic [ADDR_W-1:0] src_d,
  output logic [ADDR_W-1:0] dst_d,
  output logic              busy,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_src,
  output logic [ADDR_W-1:0] wb_dst,
  output logic              ctl_done,
  output logic              ctl_dec
);

  localparam logic [ADDR_W-1:0] WIN_MASK = (ADDR_W'(1) << WIN_W) - ADDR_W'(1);

  logic [ADDR_W-1:0]     src_q, dst_q;
  logic [BLOCK_LOG2-1:0] byte_q, byte_d;
  logic [LEN_W-1:0]      left_q, left_d;
  logic                  blank_q, blank_d;
  logic                  block_end, last_byte;

  always_comb begin
    state_d   = state_q;
    src_d     = src_q;
    dst_d     = dst_q;
    byte_d    = byte_q;
    left_d    = left_q;
    blank_d   = blank_q;
    block_end = 1'b0;
    last_byte = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          src_d   = cmd.src;
          dst_d   = cmd.dst;
          blank_d = cmd.blank_mode;
          left_d  = cmd.blocks;
          byte_d  = '0;
          state_d = cmd.blank_mode ? ST_HOLD : ST_READ;
        end
      end
      ST_HOLD: begin
        if (hblank_pulse) state_d = ST_READ;
      end
      ST_READ: begin
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        src_d  = src_q + ADDR_W'(1);
        dst_d  = (dst_q & ~WIN_MASK) | ((dst_q + ADDR_W'(1)) & WIN_MASK);
        byte_d = byte_q + BLOCK_LOG2'(1);
        if (byte_q == '1) begin
          block_end = 1'b1;
          if (left_q == '0) begin
            last_byte = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            left_d  = left_q - LEN_W'(1);
            state_d = blank_q ? ST_HOLD : ST_READ;
          end
        end else begin
          state_d = ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      byte_q  <= '0;
      left_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      byte_q  <= byte_d;
      left_q  <= left_d;
      blank_q <= blank_d;
    end
  end

  always_comb begin
    busy     = (state_q != ST_IDLE);
    wb_en    = last_byte;
    wb_src   = src_d;
    wb_dst   = dst_d;
    ctl_done = last_byte && !blank_q;
    ctl_dec  = block_end && blank_q;
  end

endmodule

// File: rtl/hdma_port.sv
// Bus port: registers every bus output from the sequencer's next state
// and captures the read byte for the following write cycle.
module hdma_port
  import hdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  hdma_state_e       state_q,
  input  hdma_state_e       state_d,
  input  logic [ADDR_W-1:0] src_d,
  input  logic [ADDR_W-1:0] dst_d,
  input  logic [REG_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [REG_W-1:0]  bus_wdata,
  output logic              bus_we,
  output logic              cpu_stall
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_we    <= 1'b0;
      cpu_stall <= 1'b0;
      bus_wdata <= '0;
    end else begin
      case (state_d)
        ST_READ:  bus_addr <= src_d;
        ST_WRITE: bus_addr <= dst_d;
        default:  bus_addr <= '0;
      endcase
      bus_we    <= (state_d == ST_WRITE);
      cpu_stall <= (state_d == ST_READ) || (state_d == ST_WRITE);
      if (state_q == ST_READ) bus_wdata <= bus_rdata;
    end
  end

endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import hdma_pkg::*;
#(
  parameter int                BLOCK_LOG2 = 4,
  parameter int                WIN_W      = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [2:0]        cfg_rsel,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              hblank_pulse,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  bus_wdata,
  output logic              bus_we,
  output logic              cpu_stall
);

  hdma_cmd_t         cmd;
  hdma_state_e       state_q, state_d;
  logic              start, busy, wb_en, ctl_done, ctl_dec;
  logic [ADDR_W-1:0] src_d, dst_d, wb_src, wb_dst;

  hdma_regs #(
    .BLOCK_LOG2(BLOCK_LOG2),
    .WIN_W     (WIN_W),
    .WIN_BASE  (WIN_BASE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .cfg_rsel (cfg_rsel),
    .cfg_rdata(cfg_rdata),
    .busy     (busy),
    .wb_en    (wb_en),
    .wb_src   (wb_src),
    .wb_dst   (wb_dst),
    .ctl_done (ctl_done),
    .ctl_dec  (ctl_dec),
    .start    (start),
    .cmd      (cmd)
  );

  hdma_seq #(
    .BLOCK_LOG2(BLOCK_LOG2),
    .WIN_W     (WIN_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cmd         (cmd),
    .hblank_pulse(hblank_pulse),
    .state_q     (state_q),
    .state_d     (state_d),
    .src_d       (src_d),
    .dst_d       (dst_d),
    .busy        (busy),
    .wb_en       (wb_en),
    .wb_src      (wb_src),
    .wb_dst      (wb_dst),
    .ctl_done    (ctl_done),
    .ctl_dec     (ctl_dec)
  );

  hdma_port u_port (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .state_d  (state_d),
    .src_d    (src_d),
    .dst_d    (dst_d),
    .bus_rdata(bus_rdata),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .cpu_stall(cpu_stall)
  );

endmodule

// File: rtl/hdma_checker.sv
module hdma_checker #(
  parameter int          WIN_W    = 13,
  parameter logic [15:0] WIN_BASE = 16'h8000
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        bus_we,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        cpu_stall
);

  localparam logic [15:0] WIN_MASK = (16'd1 << WIN_W) - 16'd1;

  // Every write lands in the video window
  assert_write_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> ((bus_addr & ~WIN_MASK) == WIN_BASE));

  // Writes only happen while the CPU is held off
  assert_write_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> cpu_stall);

  // A read cycle is always followed by a write cycle
  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && !bus_we) |=> bus_we);

  // A write never lasts more than one cycle
  assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we);

  // The byte written is the byte returned in the preceding read cycle
  assert_copy_data_R7: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> (bus_wdata == $past(bus_rdata)));

  // Back-to-back reads step the source by one
  assert_src_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && !bus_we && $past(cpu_stall && !bus_we, 2))
      |-> (bus_addr == $past(bus_addr, 2) + 16'd1));

endmodule

bind vram_dma_engine hdma_checker #(
  .WIN_W   (WIN_W),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cpu_stall(cpu_stall)
);

// File: tb/vram_dma_engine_test.sv
module vram_dma_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [2:0]  cfg_rsel = '0;
  logic [7:0]  cfg_rdata;
  logic        hblank_pulse = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic        cpu_stall;

  always #10 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign bus_rdata = src_byte(bus_addr);

  vram_dma_engine uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .hblank_pulse(hblank_pulse), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .cpu_stall(cpu_stall)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st;        // 0 idle, 1 waiting for blank, 2 read, 3 write
  int m_src, m_dst, m_cnt, m_left;
  bit m_blank;
  int m_reg [5];
  int e_addr, e_we, e_stall, e_wdata;

  task automatic model_step();
    int  src_al;
    bit  go;
    src_al = ((m_reg[0] << 8) | m_reg[1]) & 'hFFF0;
    go = cfg_we && cfg_sel == 3'd4 && m_st == 0 &&
         !(src_al >= 'h8000 && src_al < 'hA000);
    if (cfg_we && cfg_sel < 3'd4) m_reg[cfg_sel] = int'(cfg_wdata);
    case (m_st)
      0: if (go) begin
           m_reg[4] = int'(cfg_wdata);
           m_src    = src_al;
           m_dst    = (((m_reg[2] << 8) | m_reg[3]) & 'h1FF0) | 'h8000;
           m_blank  = cfg_wdata[7];
           m_left   = int'(cfg_wdata[6:0]);
           m_cnt    = 0;
           m_st     = m_blank ? 1 : 2;
         end
      1: if (hblank_pulse) m_st = 2;
      2: begin e_wdata = int'(src_byte(16'(m_src))); m_st = 3; end
      default: begin
        m_src = (m_src + 1) & 'hFFFF;
        m_dst = 'h8000 | ((m_dst + 1) & 'h1FFF);
        m_cnt++;
        if (m_cnt == 16) begin
          m_cnt = 0;
          if (m_blank) m_reg[4] = (m_reg[4] - 1) & 'hFF;
          if (m_left == 0) begin
            m_st = 0;
            m_reg[0] = m_src >> 8;  m_reg[1] = m_src & 'hFF;
            m_reg[2] = m_dst >> 8;  m_reg[3] = m_dst & 'hFF;
            if (!m_blank) m_reg[4] = m_reg[4] | 'h80;
          end else begin
            m_left--;
            m_st = m_blank ? 1 : 2;
          end
        end else m_st = 2;
      end
    endcase
    e_stall = (m_st >= 2) ? 1 : 0;
    e_we    = (m_st == 3) ? 1 : 0;
    e_addr  = (m_st == 2) ? m_src : (m_st == 3) ? m_dst : 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_left = 0; m_blank = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
      e_addr = 0; e_we = 0; e_stall = 0; e_wdata = 0;
    end else begin
      model_step();
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7 bus_addr", int'(bus_addr), e_addr);
      check("R7 bus_we", int'(bus_we), e_we);
      check("R7 bus_wdata", int'(bus_wdata), e_wdata);
      check("R6 cpu_stall", int'(cpu_stall), e_stall);
      check("R1 cfg_rdata", int'(cfg_rdata), (cfg_rsel < 3'd5) ? m_reg[cfg_rsel] : 'hFF);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #2; cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic blank_pulse();
    hblank_pulse = 1'b1;
    tick();
    hblank_pulse = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] sel, input int exp);
    cfg_rsel = sel;
    #1;
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic run_to_idle();
    int guard = 0;
    while (cpu_stall && guard < 5000) begin tick(); guard++; end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int c0;
    idle(3);
    rst = 1'b0;
    tick();

    // R1: reset state and readback map
    rd_check("R1 src_hi", 3'd0, 0);
    rd_check("R1 src_lo", 3'd1, 0);
    rd_check("R1 dst_hi", 3'd2, 0);
    rd_check("R1 dst_lo", 3'd3, 0);
    rd_check("R1 ctl", 3'd4, 0);
    rd_check("R1 unused selector", 3'd6, 'hFF);
    check("R1 stall", int'(cpu_stall), 0);

    // General transfer, 2 blocks, destination wraps at the window top
    reg_wr(3'd0, 8'h12); reg_wr(3'd1, 8'h34);
    reg_wr(3'd2, 8'hFF); reg_wr(3'd3, 8'hFF);
    reg_wr(3'd4, 8'h01);
    c0 = cyc;
    check("R5 general begins at once", int'(cpu_stall), 1);
    check("R2 aligned source", int'(bus_addr), 'h1230);
    tick();
    check("R4 masked destination", int'(bus_addr), 'h9FF0);
    idle(4);
    reg_wr(3'd4, 8'h05);                    // R13: ignored while busy
    reg_wr(3'd2, 8'h33);                    // R13: stored, no effect on copy
    rd_check("R13 ctl unchanged while busy", 3'd4, 'h01);
    run_to_idle();
    check("R6 general stall cycles", cyc - c0, 64);
    rd_check("R9 src_hi writeback", 3'd0, 'h12);
    rd_check("R9 src_lo writeback", 3'd1, 'h50);
    rd_check("R8 dst_hi wrapped", 3'd2, 'h80);
    rd_check("R8 dst_lo wrapped", 3'd3, 'h10);
    rd_check("R10 ctl done flag", 3'd4, 'h81);

    // R3: source inside video RAM is refused
    reg_wr(3'd0, 8'h9F); reg_wr(3'd1, 8'hFF);
    reg_wr(3'd4, 8'h00);
    check("R3 refused start no stall", int'(cpu_stall), 0);
    idle(2);
    check("R3 refused start no stall later", int'(cpu_stall), 0);
    rd_check("R3 ctl unchanged", 3'd4, 'h81);

    // R2: source wrap at top of address space, one block
    reg_wr(3'd0, 8'hFF); reg_wr(3'd1, 8'hF8);
    reg_wr(3'd2, 8'h00); reg_wr(3'd3, 8'h0F);
    reg_wr(3'd4, 8'h00);
    c0 = cyc;
    check("R2 aligned source top", int'(bus_addr), 'hFFF0);
    run_to_idle();
    check("R6 one block cycles", cyc - c0, 32);
    rd_check("R2 src_hi wrapped", 3'd0, 'h00);
    rd_check("R2 src_lo wrapped", 3'd1, 'h00);
    rd_check("R4 dst_lo", 3'd3, 'h10);
    rd_check("R10 ctl done flag len0", 3'd4, 'h80);

    // Blanking mode, 3 blocks, source 0xA000 accepted
    reg_wr(3'd0, 8'hA0); reg_wr(3'd1, 8'h00);
    reg_wr(3'd2, 8'h00); reg_wr(3'd3, 8'h40);
    reg_wr(3'd4, 8'h82);
    check("R5 blanking waits", int'(cpu_stall), 0);
    rd_check("R3 0xA000 accepted", 3'd4, 'h82);
    idle(3);
    check("R11 no pulse no copy", int'(cpu_stall), 0);
    reg_wr(3'd4, 8'h00);
    rd_check("R13 start ignored while pending", 3'd4, 'h82);
    blank_pulse();
    c0 = cyc;
    check("R11 pulse starts block", int'(bus_addr), 'hA000);
    idle(5);
    blank_pulse();                          // ignored mid-block
    run_to_idle();
    check("R11 one block per pulse", cyc - c0, 32);
    rd_check("R12 ctl after block 1", 3'd4, 'h81);
    rd_check("R9 no writeback mid-transfer", 3'd1, 'h00);
    idle(2);
    check("R11 waits for next pulse", int'(cpu_stall), 0);
    blank_pulse();
    run_to_idle();
    rd_check("R12 ctl after block 2", 3'd4, 'h80);
    blank_pulse();
    c0 = cyc;
    run_to_idle();
    check("R11 last block cycles", cyc - c0, 32);
    rd_check("R12 ctl final", 3'd4, 'h7F);
    rd_check("R9 blank src_hi", 3'd0, 'hA0);
    rd_check("R9 blank src_lo", 3'd1, 'h30);
    rd_check("R9 blank dst_hi", 3'd2, 'h80);
    rd_check("R9 blank dst_lo", 3'd3, 'h70);
    blank_pulse();
    check("R11 pulse while idle ignored", int'(cpu_stall), 0);
    idle(2);
    check("R11 still idle", int'(cpu_stall), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule